// File: doc/BRIEF.md
# Video Ancillary Packet Flag Generator

This block sits on the 10-bit word path of a video receiver, clocked by the pixel clock. It marks the words that belong to an ancillary data packet. A packet begins with the three-word start pattern 0x000, 0x3FF, 0x3FF. After the pattern come a data identifier word, a secondary identifier word and a data count word. Then come as many user words as the count gives, and the packet ends with one checksum word. Packets are found wherever they occur, in horizontal or vertical blanking alike. No timing reference decode is needed.

The video words leave the block three clocks after they arrive. This delay lets each flag rise together with the first start-pattern word on the output, although that word can only be recognised once the two words after it have been seen. Each flag is a plain registered level on the pixel clock, so downstream logic can use it directly as a clock enable or as a memory write enable.

Two select inputs decide how the flags are formed. In high-definition mode, and in standard-definition mode with the 20-bit demultiplexed format, each flag follows its own stream: the luma flag follows `y_in` and the chroma flag follows `c_in`. In standard-definition mode with the 10-bit multiplexed format, the single stream arrives on `y_in` and both flags rise and fall together.

Top module: `anc_flag_gen`

## Requirements
- R1: `y_out` and `c_out` repeat `y_in` and `c_in` exactly three clocks later: a word sampled at a rising edge appears on the output after the third rising edge that follows.
- R2: A flag is high for exactly the output words of a packet. It rises with the 0x000 start word on the output and stays high through the checksum word, so a packet covers 7 plus N output words, where N is the data count.
- R3: Only bits 7:0 of the data count word (the sixth word of the packet) set N. Bits 9:8 have no effect on the packet length.
- R4: When a new start pattern directly follows a checksum word, the flag stays high with no gap, and the second packet is measured by its own data count.
- R5: A start pattern that is incomplete never raises a flag. Examples are 0x000, 0x3FF followed by another value, or 0x3FF, 0x3FF without a leading 0x000.
- R6: Words that match the start pattern inside a packet's user data neither restart nor lengthen that packet.
- R7: When `sd_mode` is 0 (high definition), `y_flag` tracks only packets on `y_in` and `c_flag` tracks only packets on `c_in`, whatever `mux10` is.
- R8: When `sd_mode` is 1 and `mux10` is 0 (20-bit demultiplexed), the two flags operate independently, each following its own stream.
- R9: When `sd_mode` is 1 and `mux10` is 1 (10-bit multiplexed), both flags equal the packet flag of `y_in`, and `c_in` has no effect on either flag.
- R10: A synchronous active-high `rst` drives both flags low from the next edge and returns the parser to idle, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_mode | input | 1 | 1 = standard definition, 0 = high definition |
| mux10 | input | 1 | 1 = 10-bit multiplexed format, 0 = 20-bit demultiplexed (used in standard definition only) |
| y_in | input | 10 | Luma stream, or the multiplexed stream |
| c_in | input | 10 | Chroma stream |
| y_out | output | 10 | `y_in` delayed by three clocks |
| c_out | output | 10 | `c_in` delayed by three clocks |
| y_flag | output | 1 | Luma ancillary flag, aligned with `y_out` |
| c_flag | output | 1 | Chroma ancillary flag, aligned with `c_out` |

## Verification
The bench covers the smallest packets (counts 0, 1 and 2), the largest (count 255), and a count word with bits 9:8 set. A parser that read all ten bits would run on for hundreds of words, and one that was off by one in counting would drop the flag a word early or late. It sends packets back to back, and false start patterns both outside packets and buried in user data. A design that dropped the flag between packets, latched onto a two-word partial pattern, or restarted inside user data would show a flag edge in the wrong place. Every stream runs in all four select combinations, so a wrong choice of which lane drives `c_flag` shows up. A reset in the middle of a packet followed by 0x3FF words catches a parser that keeps its count across reset.

// File: rtl/anc_flag_pkg.sv
package anc_flag_pkg;

    // Width of one video word.
    localparam int ANC_W = 10;
    // Length of the start pattern; the output delay equals it.
    localparam int PRE_LEN = 3;
    // Number of parallel word lanes (luma, chroma).
    localparam int NUM_LANES = 2;
    // Bits of the data count word that carry the user word count.
    localparam int CNT_W = 8;

    typedef logic [ANC_W-1:0] word_t;
    typedef logic [CNT_W-1:0] count_t;

    localparam word_t WORD_ZERO  = '0;
    localparam word_t WORD_ONES  = '1;
    // Value held by the delay stages after reset.
    localparam word_t BLANK_WORD = word_t'(10'h040);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE2,
        ST_PRE3,
        ST_DID,
        ST_SDID,
        ST_DC,
        ST_USER,
        ST_CS
    } pstate_e;

    typedef struct packed {
        pstate_e st;
        count_t  left;
    } parse_t;

    localparam parse_t PARSE_RESET = '{st: ST_IDLE, left: '0};

    // True when three consecutive words (oldest first) form the start pattern.
    function automatic logic is_start(input word_t w_old, input word_t w_mid, input word_t w_new);
        return (w_old == WORD_ZERO) && (w_mid == WORD_ONES) && (w_new == WORD_ONES);
    endfunction

endpackage

// File: rtl/anc_word_delay.sv
module anc_word_delay
    import anc_flag_pkg::*;
#(
    parameter int DEPTH = PRE_LEN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  word_t                 din,
    output logic [DEPTH-1:0][ANC_W-1:0] taps
);

    // Stage 0 holds the newest word, stage DEPTH-1 the oldest.
    always_ff @(posedge clk) begin
        if (rst) taps[0] <= BLANK_WORD;
        else     taps[0] <= din;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) taps[s] <= BLANK_WORD;
            else     taps[s] <= taps[s-1];
        end

        // R1: each stage passes its neighbour's word on one clock later
        a_r1_stage_shift: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> taps[s] == $past(taps[s-1]));
    end

    a_r1_first_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> taps[0] == $past(din));

endmodule

// File: rtl/anc_packet_parser.sv
module anc_packet_parser
    import anc_flag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t now_word,   // word entering the block this cycle
    input  word_t look_word,  // word one clock older
    input  word_t cand_word,  // word being classified (two clocks older)
    input  word_t out_word,   // word currently on the delayed output
    output logic  flag
);

    parse_t cur, nxt;
    logic   mark;

    // Classify the candidate word; the two newer words give the lookahead
    // needed to confirm a start pattern on its first word.
    always_comb begin
        nxt  = cur;
        mark = 1'b0;
        unique case (cur.st)
            ST_IDLE: begin
                if (is_start(cand_word, look_word, now_word)) begin
                    mark   = 1'b1;
                    nxt.st = ST_PRE2;
                end
            end
            ST_PRE2: begin
                mark   = 1'b1;
                nxt.st = ST_PRE3;
            end
            ST_PRE3: begin
                mark   = 1'b1;
                nxt.st = ST_DID;
            end
            ST_DID: begin
                mark   = 1'b1;
                nxt.st = ST_SDID;
            end
            ST_SDID: begin
                mark   = 1'b1;
                nxt.st = ST_DC;
            end
            ST_DC: begin
                mark     = 1'b1;
                nxt.left = cand_word[CNT_W-1:0];
                nxt.st   = (cand_word[CNT_W-1:0] == '0) ? ST_CS : ST_USER;
            end
            ST_USER: begin
                mark     = 1'b1;
                nxt.left = cur.left - count_t'(1);
                nxt.st   = (cur.left == count_t'(1)) ? ST_CS : ST_USER;
            end
            ST_CS: begin
                mark   = 1'b1;
                nxt.st = ST_IDLE;
            end
            default: begin
                nxt = PARSE_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= PARSE_RESET;
            flag <= 1'b0;
        end else begin
            cur  <= nxt;
            flag <= mark;
        end
    end

    // R2: a flag only rises when the start word reaches the output
    a_r2_rise_on_start_word: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> out_word == WORD_ZERO);

    // R2: the checksum word is still covered by the flag
    a_r2_checksum_covered: assert property (@(posedge clk) disable iff (rst)
        cur.st == ST_CS |=> flag);

    // R3: a user word phase never runs with an exhausted count
    a_r3_count_live: assert property (@(posedge clk) disable iff (rst)
        cur.st == ST_USER |-> cur.left != '0);

    // R6: user data cannot send the parser back into a start pattern
    a_r6_payload_no_restart: assert property (@(posedge clk) disable iff (rst)
        cur.st == ST_USER |=> (cur.st == ST_USER || cur.st == ST_CS));

endmodule

// File: rtl/anc_flag_gen.sv
module anc_flag_gen
    import anc_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sd_mode,
    input  logic             mux10,
    input  logic [ANC_W-1:0] y_in,
    input  logic [ANC_W-1:0] c_in,
    output logic [ANC_W-1:0] y_out,
    output logic [ANC_W-1:0] c_out,
    output logic             y_flag,
    output logic             c_flag
);

    localparam int LUMA   = 0;
    localparam int CHROMA = 1;

    logic [NUM_LANES-1:0][ANC_W-1:0] lane_in;
    logic [NUM_LANES-1:0][ANC_W-1:0] lane_out;
    logic [NUM_LANES-1:0]            lane_flag;

    assign lane_in[LUMA]   = y_in;
    assign lane_in[CHROMA] = c_in;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [PRE_LEN-1:0][ANC_W-1:0] taps;

        anc_word_delay #(.DEPTH(PRE_LEN)) u_delay (
            .clk  (clk),
            .rst  (rst),
            .din  (lane_in[g]),
            .taps (taps)
        );

        anc_packet_parser u_parser (
            .clk       (clk),
            .rst       (rst),
            .now_word  (lane_in[g]),
            .look_word (taps[0]),
            .cand_word (taps[1]),
            .out_word  (taps[PRE_LEN-1]),
            .flag      (lane_flag[g])
        );

        assign lane_out[g] = taps[PRE_LEN-1];
    end

    // In standard-definition multiplexed format one stream carries all
    // packets, so its flag is reported on both outputs.
    logic shared_stream;
    assign shared_stream = sd_mode & mux10;

    assign y_out  = lane_out[LUMA];
    assign c_out  = lane_out[CHROMA];
    assign y_flag = lane_flag[LUMA];
    assign c_flag = shared_stream ? lane_flag[LUMA] : lane_flag[CHROMA];

endmodule

// File: tb/anc_flag_gen_bench.sv
module anc_flag_gen_bench;
    import anc_flag_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        rst = 1'b1;
    logic        sd_mode = 1'b0;
    logic        mux10 = 1'b0;
    logic [9:0]  y_in = 10'h040;
    logic [9:0]  c_in = 10'h040;
    logic [9:0]  y_out, c_out;
    logic        y_flag, c_flag;

    anc_flag_gen u_anc_flag_gen (
        .clk(clk), .rst(rst), .sd_mode(sd_mode), .mux10(mux10),
        .y_in(y_in), .c_in(c_in), .y_out(y_out), .c_out(c_out),
        .y_flag(y_flag), .c_flag(c_flag)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [9:0] ys [0:1023];
    logic [9:0] cs [0:1023];
    bit         ym [0:1023];
    bit         cm [0:1023];
    int         yt [0:1023];
    int         ylen = 0;
    int         clen = 0;

    task automatic chk(input bit ok, input int tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int lane, input logic [9:0] w, input bit m, input int tag);
        if (lane == 0) begin
            ys[ylen] = w; ym[ylen] = m; yt[ylen] = tag; ylen++;
        end else begin
            cs[clen] = w; cm[clen] = m; clen++;
        end
    endtask

    task automatic gap(input int lane, input int n, input int tag);
        for (int k = 0; k < n; k++) put(lane, 10'h040 + 10'(k), 1'b0, tag);
    endtask

    // Packet: start pattern, two ids, count word, N user words, checksum.
    task automatic packet(input int lane, input logic [9:0] dcw, input int tag, input bit inject);
        int n;
        n = int'(dcw[7:0]);
        put(lane, 10'h000, 1'b1, tag);
        put(lane, 10'h3FF, 1'b1, tag);
        put(lane, 10'h3FF, 1'b1, tag);
        put(lane, 10'h241, 1'b1, tag);
        put(lane, 10'h101, 1'b1, tag);
        put(lane, dcw,     1'b1, tag);
        for (int k = 0; k < n; k++) begin
            if (inject && k == 0)      put(lane, 10'h000, 1'b1, tag);
            else if (inject && k < 3)  put(lane, 10'h3FF, 1'b1, tag);
            else                       put(lane, 10'h100 + 10'(k & 8'hFF), 1'b1, tag);
        end
        put(lane, 10'h2AA, 1'b1, tag);
    endtask

    // R5: incomplete start patterns
    task automatic partial(input int lane, input int tag);
        put(lane, 10'h000, 1'b0, tag);
        put(lane, 10'h3FF, 1'b0, tag);
        put(lane, 10'h040, 1'b0, tag);
        put(lane, 10'h3FF, 1'b0, tag);
        put(lane, 10'h3FF, 1'b0, tag);
        put(lane, 10'h080, 1'b0, tag);
        put(lane, 10'h000, 1'b0, tag);
        put(lane, 10'h200, 1'b0, tag);
    endtask

    task automatic build_streams();
        gap(0, 4, 2);
        packet(0, {2'b10, 8'd0}, 2, 1'b0);      // R2 empty packet
        gap(0, 2, 2);
        packet(0, {2'b10, 8'd1}, 2, 1'b0);
        packet(0, {2'b10, 8'd2}, 4, 1'b0);      // R4 back to back
        packet(0, {2'b01, 8'd0}, 4, 1'b0);      // R4 third in a row
        gap(0, 3, 5);
        partial(0, 5);                          // R5
        gap(0, 2, 5);
        packet(0, {2'b11, 8'd3}, 3, 1'b0);      // R3 upper count bits set
        gap(0, 1, 6);
        packet(0, {2'b10, 8'd6}, 6, 1'b1);      // R6 pattern in user data
        gap(0, 2, 2);
        packet(0, {2'b01, 8'd255}, 2, 1'b0);    // R2 largest packet
        gap(0, 4, 2);

        gap(1, 9, 0);
        packet(1, {2'b10, 8'd4}, 0, 1'b0);
        gap(1, 1, 0);
        partial(1, 0);
        gap(1, 3, 0);
        packet(1, {2'b01, 8'd255}, 0, 1'b0);
        packet(1, {2'b10, 8'd1}, 0, 1'b0);
        gap(1, 6, 0);

        while (ylen < clen) put(0, 10'h040, 1'b0, 2);
        while (clen < ylen) put(1, 10'h040, 1'b0, 0);
    endtask

    task automatic run_combo(input bit sd, input bit mx, input int ctag);
        int total;
        total = ylen;
        @(negedge clk);
        sd_mode = sd;
        mux10 = mx;
        rst = 1'b1;
        y_in = 10'h3FF;
        c_in = 10'h3FF;
        repeat (4) @(negedge clk);
        chk(y_flag == 1'b0, 10, "y_flag in reset", int'(y_flag), 0);   // R10
        chk(c_flag == 1'b0, 10, "c_flag in reset", int'(c_flag), 0);   // R10
        rst = 1'b0;
        for (int j = 0; j < total + PRE_LEN; j++) begin
            if (j >= PRE_LEN) begin
                int i;
                bit cexp;
                int ftag;
                i = j - PRE_LEN;
                chk(y_out == ys[i], 1, "y_out delay", int'(y_out), int'(ys[i]));   // R1
                chk(c_out == cs[i], 1, "c_out delay", int'(c_out), int'(cs[i]));   // R1
                chk(y_flag == ym[i], yt[i], "y_flag", int'(y_flag), int'(ym[i]));
                cexp = (sd && mx) ? ym[i] : cm[i];                                 // R7 R8 R9
                ftag = (sd && mx) ? 9 : ctag;
                chk(c_flag == cexp, ftag, "c_flag", int'(c_flag), int'(cexp));
            end
            y_in = (j < total) ? ys[j] : 10'h040;
            c_in = (j < total) ? cs[j] : 10'h040;
            @(negedge clk);
        end
    endtask

    task automatic reset_mid_packet();
        logic [9:0] seq [0:5];
        seq[0] = 10'h000; seq[1] = 10'h3FF; seq[2] = 10'h3FF;
        seq[3] = 10'h241; seq[4] = 10'h101; seq[5] = {2'b10, 8'd5};
        sd_mode = 1'b0;
        mux10 = 1'b0;
        for (int j = 0; j < 6; j++) begin
            y_in = seq[j];
            c_in = 10'h040;
            @(negedge clk);
        end
        // Output now shows the fourth packet word.
        chk(y_flag == 1'b1, 2, "y_flag before mid reset", int'(y_flag), 1);
        rst = 1'b1;
        y_in = 10'h3FF;
        @(negedge clk);
        chk(y_flag == 1'b0, 10, "y_flag after mid reset", int'(y_flag), 0);   // R10
        chk(c_flag == 1'b0, 10, "c_flag after mid reset", int'(c_flag), 0);   // R10
        rst = 1'b0;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            chk(y_flag == 1'b0, 10, "parser idle after reset", int'(y_flag), 0); // R10
        end
    endtask

    initial begin
        build_streams();
        run_combo(1'b0, 1'b0, 7);   // R7 HD, mux10 low
        run_combo(1'b0, 1'b1, 7);   // R7 HD, mux10 ignored
        run_combo(1'b1, 1'b0, 8);   // R8 SD 20-bit
        run_combo(1'b1, 1'b1, 9);   // R9 SD 10-bit multiplexed
        reset_mid_packet();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule